// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number and a per-slot mask that widens the page it covers. It also holds an address-space tag, a global flag that lets the slot serve every address space, two valid flags, and two physical frame fields. An access port looks up a virtual address against the whole table in the same cycle. In that same cycle it flags uncacheable addresses and misaligned instruction fetches, and it counts hits and misses for reads and writes.

A separate probe port searches the table with a bare page number and returns a signed index, or -1 when no slot matches. Software-style maintenance works through an indexed write port, an indexed read port and a whole-table flush. A round-robin pointer names the next slot to replace. The pointer shows that slot's contents and steps forward only on request.

Top module: `asid_tlb`

## Requirements
- R1: A slot matches a page number when the stored and requested page numbers agree in every bit where the slot's mask is 0; bits where the mask is 1 are ignored. The page number of an access is `acc_va_i[31:12]`.
- R2: A slot also needs its global flag set, or a requested address-space tag equal to the stored one.
- R3: A slot with both valid flags clear never matches. If several slots match, the lowest index wins. On a hit, `lk_hit_o`=1 and `lk_idx_o`/`lk_entry_o` give the winning slot. On a miss, all three outputs are 0. Lookup is combinational from the current table.
- R4: `pr_idx_o` gives the lowest matching index for `pr_vpn_i`/`pr_asid_i`, using the rules of R1 to R3, or -1 (all ones) on a miss.
- R5: A write with `wr_idx_i` below the slot count replaces that slot at the clock edge, whatever it held before. `rd_entry_o` returns the slot at `rd_idx_i`. The slot layout, from LSB up, is: page number [19:0], mask [39:20], tag [47:40], global [48], valid0 [49], valid1 [50], frame0 [70:51], frame1 [90:71].
- R6: A write with `wr_idx_i` at or beyond the slot count changes no slot. `wr_warn_o` is high for the cycle after that edge and is low otherwise.
- R7: `flush_i` zeroes every slot and the pointer at the edge, and it takes precedence over a write or pointer step in the same cycle.
- R8: `rr_entry_o` shows the slot at `rr_idx_o`. The pointer moves by one only on an edge with `rr_adv_i` high, wrapping from the last slot to 0.
- R9: `uncached_o` is 1 exactly when `acc_va_i & 32'hA000_0000 == 32'hA000_0000`.
- R10: `align_fault_o` is 1 exactly when `acc_kind_i` is 2 (instruction fetch) and `acc_va_i[1:0]` is nonzero.
- R11: On each edge with `acc_valid_i`, one counter rises by 1. A write hit goes to the write-hit counter and a write miss to the write-miss counter; any other kind goes to the read-hit or read-miss counter. Kind encoding: 0 read, 1 write, 2 fetch, 3 read. The totals are the sums of the read and write counts. A flush does not clear the counters.
- R12: After reset, every slot, the pointer, the warning and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access present, counted |
| acc_kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_va_i | input | 32 | Access virtual address |
| acc_asid_i | input | 8 | Access address-space tag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | 3 | Winning slot index |
| lk_entry_o | output | 91 | Winning slot contents |
| uncached_o | output | 1 | Address falls in uncacheable window |
| align_fault_o | output | 1 | Misaligned instruction fetch |
| pr_vpn_i | input | 20 | Probe page number |
| pr_asid_i | input | 8 | Probe address-space tag |
| pr_idx_o | output | 4 | Signed probe result, -1 on miss |
| wr_en_i | input | 1 | Indexed write strobe |
| wr_idx_i | input | 4 | Write index, may be out of range |
| wr_entry_i | input | 91 | Slot contents to write |
| wr_warn_o | output | 1 | Last write was out of range |
| rd_idx_i | input | 3 | Read index |
| rd_entry_o | output | 91 | Slot at read index |
| rr_adv_i | input | 1 | Step the replacement pointer |
| rr_idx_o | output | 3 | Replacement pointer |
| rr_entry_o | output | 91 | Slot at the pointer |
| flush_i | input | 1 | Clear the table and the pointer |
| rd_hit_cnt_o | output | 16 | Read hits |
| rd_miss_cnt_o | output | 16 | Read misses |
| wr_hit_cnt_o | output | 16 | Write hits |
| wr_miss_cnt_o | output | 16 | Write misses |
| hit_total_o | output | 17 | All hits |
| miss_total_o | output | 17 | All misses |
| acc_total_o | output | 17 | All accesses |

## Verification
The assertions check, on every edge, these properties: an out-of-range write leaves the table untouched, a flush empties the table and the pointer, the pointer holds or wraps as the step input asks, probe and lookup agree when they are given the same page and tag, and each counted access moves exactly one counter. What only the bench's scenarios can show is the matching itself. That covers how masked bits are ignored, how the global flag bypasses the tag, how empty slots are skipped and how the lowest index wins. The bench's scenarios also cover the uncacheable and fault decodes, and the exact split of hits and misses over the counters. A behavioural model compares all of these against the ports on every cycle, across directed cases and random traffic.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  parameter int VA_W   = 32;
  parameter int PG_SH  = 12;
  parameter int VPN_W  = VA_W - PG_SH;
  parameter int ASID_W = 8;
  parameter int PFN_W  = 20;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn1;
    logic [PFN_W-1:0]  pfn0;
    logic              v1;
    logic              v0;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  mask;
    logic [VPN_W-1:0]  vpn;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RD2   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/asid_tlb_match.sv
module asid_tlb_match
  import asid_tlb_pkg::*;
#(
  parameter int N = 8
) (
  input  entry_t [N-1:0]    tbl_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic [N-1:0]      hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic occ, pg_eq, id_ok;
    assign occ   = tbl_i[i].v0 | tbl_i[i].v1;
    assign pg_eq = ((vpn_i ^ tbl_i[i].vpn) & ~tbl_i[i].mask) == '0;
    assign id_ok = tbl_i[i].glob | (asid_i == tbl_i[i].asid);
    assign hit_o[i] = occ & pg_eq & id_ok;
  end
endmodule

// File: rtl/asid_tlb_prio.sv
module asid_tlb_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest set bit is assigned last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/asid_tlb_stats.sv
module asid_tlb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             is_wr_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] rd_hit_o,
  output logic [CNT_W-1:0] rd_miss_o,
  output logic [CNT_W-1:0] wr_hit_o,
  output logic [CNT_W-1:0] wr_miss_o,
  output logic [CNT_W:0]   hit_tot_o,
  output logic [CNT_W:0]   miss_tot_o,
  output logic [CNT_W:0]   acc_tot_o
);
  logic [CNT_W-1:0] rh_q, rm_q, wh_q, wm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rh_q <= '0; rm_q <= '0; wh_q <= '0; wm_q <= '0;
    end else if (valid_i) begin
      unique case ({is_wr_i, hit_i})
        2'b01:   rh_q <= rh_q + 1'b1;
        2'b00:   rm_q <= rm_q + 1'b1;
        2'b11:   wh_q <= wh_q + 1'b1;
        default: wm_q <= wm_q + 1'b1;
      endcase
    end
  end

  assign rd_hit_o   = rh_q;
  assign rd_miss_o  = rm_q;
  assign wr_hit_o   = wh_q;
  assign wr_miss_o  = wm_q;
  assign hit_tot_o  = {1'b0, rh_q} + {1'b0, wh_q};
  assign miss_tot_o = {1'b0, rm_q} + {1'b0, wm_q};
  assign acc_tot_o  = hit_tot_o + miss_tot_o;

  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_wr_i) |=> (CNT_W'(rh_q + rm_q) == CNT_W'($past(rh_q + rm_q) + 1'b1))
                              && $stable(wh_q) && $stable(wm_q)); // R11
  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_wr_i) |=> (CNT_W'(wh_q + wm_q) == CNT_W'($past(wh_q + wm_q) + 1'b1))
                             && $stable(rh_q) && $stable(rm_q)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({rh_q, rm_q, wh_q, wm_q})); // R11
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int          NUM_ENTRIES = 8,
  parameter int          CNT_W       = 16,
  parameter logic [31:0] UC_MASK     = 32'hA000_0000,
  localparam int         IW          = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    acc_valid_i,
  input  logic [1:0]              acc_kind_i,
  input  logic [VA_W-1:0]         acc_va_i,
  input  logic [ASID_W-1:0]       acc_asid_i,
  output logic                    lk_hit_o,
  output logic [IW-1:0]           lk_idx_o,
  output logic [ENT_W-1:0]        lk_entry_o,
  output logic                    uncached_o,
  output logic                    align_fault_o,
  input  logic [VPN_W-1:0]        pr_vpn_i,
  input  logic [ASID_W-1:0]       pr_asid_i,
  output logic signed [IW:0]      pr_idx_o,
  input  logic                    wr_en_i,
  input  logic [IW:0]             wr_idx_i,
  input  logic [ENT_W-1:0]        wr_entry_i,
  output logic                    wr_warn_o,
  input  logic [IW-1:0]           rd_idx_i,
  output logic [ENT_W-1:0]        rd_entry_o,
  input  logic                    rr_adv_i,
  output logic [IW-1:0]           rr_idx_o,
  output logic [ENT_W-1:0]        rr_entry_o,
  input  logic                    flush_i,
  output logic [CNT_W-1:0]        rd_hit_cnt_o,
  output logic [CNT_W-1:0]        rd_miss_cnt_o,
  output logic [CNT_W-1:0]        wr_hit_cnt_o,
  output logic [CNT_W-1:0]        wr_miss_cnt_o,
  output logic [CNT_W:0]          hit_total_o,
  output logic [CNT_W:0]          miss_total_o,
  output logic [CNT_W:0]          acc_total_o
);
  localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

  entry_t [NUM_ENTRIES-1:0] tbl_q;
  logic   [IW-1:0]          rr_q;
  logic                     warn_q;

  logic                   wr_ok;
  logic [VPN_W-1:0]       acc_vpn;
  logic [NUM_ENTRIES-1:0] lk_vec, pr_vec;
  logic                   pr_any;
  logic [IW-1:0]          pr_sel;

  assign wr_ok   = wr_idx_i < (IW+1)'(NUM_ENTRIES);
  assign acc_vpn = acc_va_i[VA_W-1 -: VPN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q  <= '0;
      rr_q   <= '0;
      warn_q <= 1'b0;
    end else begin
      warn_q <= wr_en_i & ~wr_ok;
      if (flush_i) begin
        tbl_q <= '0;
        rr_q  <= '0;
      end else begin
        if (wr_en_i && wr_ok) tbl_q[wr_idx_i[IW-1:0]] <= entry_t'(wr_entry_i);
        if (rr_adv_i) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
    end
  end

  asid_tlb_match #(.N(NUM_ENTRIES)) u_lk_match (
    .tbl_i(tbl_q), .vpn_i(acc_vpn), .asid_i(acc_asid_i), .hit_o(lk_vec));
  asid_tlb_prio #(.N(NUM_ENTRIES), .IW(IW)) u_lk_prio (
    .req_i(lk_vec), .any_o(lk_hit_o), .idx_o(lk_idx_o));

  asid_tlb_match #(.N(NUM_ENTRIES)) u_pr_match (
    .tbl_i(tbl_q), .vpn_i(pr_vpn_i), .asid_i(pr_asid_i), .hit_o(pr_vec));
  asid_tlb_prio #(.N(NUM_ENTRIES), .IW(IW)) u_pr_prio (
    .req_i(pr_vec), .any_o(pr_any), .idx_o(pr_sel));

  assign lk_entry_o = lk_hit_o ? ENT_W'(tbl_q[lk_idx_o]) : '0;
  assign pr_idx_o   = pr_any ? $signed({1'b0, pr_sel}) : '1;
  assign rd_entry_o = ({1'b0, rd_idx_i} < (IW+1)'(NUM_ENTRIES)) ? ENT_W'(tbl_q[rd_idx_i]) : '0;
  assign rr_idx_o   = rr_q;
  assign rr_entry_o = ENT_W'(tbl_q[rr_q]);
  assign wr_warn_o  = warn_q;

  assign uncached_o    = (acc_va_i & UC_MASK) == UC_MASK;
  assign align_fault_o = (acc_kind_i == ACC_FETCH) && (acc_va_i[1:0] != 2'b00);

  asid_tlb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni,
    .valid_i   (acc_valid_i),
    .is_wr_i   (acc_kind_i == ACC_WR),
    .hit_i     (lk_hit_o),
    .rd_hit_o  (rd_hit_cnt_o),
    .rd_miss_o (rd_miss_cnt_o),
    .wr_hit_o  (wr_hit_cnt_o),
    .wr_miss_o (wr_miss_cnt_o),
    .hit_tot_o (hit_total_o),
    .miss_tot_o(miss_total_o),
    .acc_tot_o (acc_total_o));

  AST_OOR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok && !flush_i) |=> $stable(tbl_q)); // R6
  AST_OOR_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok) |=> wr_warn_o); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tbl_q == '0 && rr_q == '0)); // R7
  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rr_adv_i && !flush_i) |=> $stable(rr_q)); // R8
  AST_RR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_adv_i && !flush_i && rr_q == LAST) |=> rr_q == '0); // R8
  AST_PROBE_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_vpn_i == acc_vpn && pr_asid_i == acc_asid_i)
      |-> (lk_hit_o ? (pr_idx_o == $signed({1'b0, lk_idx_o})) : (pr_idx_o < 0))); // R4
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int N   = 8;
  localparam int IW  = 3;
  localparam int EW  = 91;
  localparam int CW  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          acc_valid_i = 0;
  logic [1:0]    acc_kind_i = 0;
  logic [31:0]   acc_va_i = 0;
  logic [7:0]    acc_asid_i = 0;
  logic          lk_hit_o;
  logic [IW-1:0] lk_idx_o;
  logic [EW-1:0] lk_entry_o;
  logic          uncached_o, align_fault_o;
  logic [19:0]   pr_vpn_i = 0;
  logic [7:0]    pr_asid_i = 0;
  logic signed [IW:0] pr_idx_o;
  logic          wr_en_i = 0;
  logic [IW:0]   wr_idx_i = 0;
  logic [EW-1:0] wr_entry_i = 0;
  logic          wr_warn_o;
  logic [IW-1:0] rd_idx_i = 0;
  logic [EW-1:0] rd_entry_o;
  logic          rr_adv_i = 0;
  logic [IW-1:0] rr_idx_o;
  logic [EW-1:0] rr_entry_o;
  logic          flush_i = 0;
  logic [CW-1:0] rd_hit_cnt_o, rd_miss_cnt_o, wr_hit_cnt_o, wr_miss_cnt_o;
  logic [CW:0]   hit_total_o, miss_total_o, acc_total_o;

  asid_tlb u_asid_tlb (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic [EW-1:0] m_tbl [N];
  int m_rr = 0, m_rh = 0, m_rm = 0, m_wh = 0, m_wm = 0;
  bit m_warn = 0;

  task automatic chk(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [EW-1:0] mk(logic [19:0] vpn, logic [19:0] msk, logic [7:0] asid,
                                       bit g, bit v0, bit v1, logic [19:0] f0, logic [19:0] f1);
    return {f1, f0, v1, v0, g, asid, msk, vpn};
  endfunction

  function automatic int m_find(logic [19:0] vpn, logic [7:0] asid);
    for (int i = 0; i < N; i++) begin
      logic [EW-1:0] e = m_tbl[i];
      if ((e[49] || e[50]) && (((vpn ^ e[19:0]) & ~e[39:20]) == 20'h0) &&
          (e[48] || asid == e[47:40])) return i;
    end
    return -1;
  endfunction

  task automatic compare_all();
    int li = m_find(acc_va_i[31:12], acc_asid_i);
    int pi = m_find(pr_vpn_i, pr_asid_i);
    logic [EW-1:0] le = (li >= 0) ? m_tbl[li] : '0;
    logic [IW:0] pexp = (IW+1)'(pi);
    chk(lk_hit_o == (li >= 0), "R3 lk_hit", 96'(lk_hit_o), 96'(li >= 0));
    chk(lk_idx_o == IW'((li >= 0) ? li : 0), "R3 lk_idx", 96'(lk_idx_o), 96'((li >= 0) ? li : 0));
    chk(lk_entry_o == le, "R3 lk_entry", 96'(lk_entry_o), 96'(le));
    chk(pr_idx_o == pexp, "R4 probe", 96'(pr_idx_o), 96'(pexp));
    chk(rd_entry_o == m_tbl[rd_idx_i], "R5 read", 96'(rd_entry_o), 96'(m_tbl[rd_idx_i]));
    chk(rr_idx_o == IW'(m_rr), "R8 rr_idx", 96'(rr_idx_o), 96'(m_rr));
    chk(rr_entry_o == m_tbl[m_rr], "R8 rr_entry", 96'(rr_entry_o), 96'(m_tbl[m_rr]));
    chk(wr_warn_o == m_warn, "R6 warn", 96'(wr_warn_o), 96'(m_warn));
    chk(uncached_o == ((acc_va_i & 32'hA000_0000) == 32'hA000_0000), "R9 uncached",
        96'(uncached_o), 96'((acc_va_i & 32'hA000_0000) == 32'hA000_0000));
    chk(align_fault_o == (acc_kind_i == 2 && acc_va_i[1:0] != 0), "R10 align",
        96'(align_fault_o), 96'(acc_kind_i == 2 && acc_va_i[1:0] != 0));
    chk(rd_hit_cnt_o == CW'(m_rh), "R11 rd_hit", 96'(rd_hit_cnt_o), 96'(m_rh));
    chk(rd_miss_cnt_o == CW'(m_rm), "R11 rd_miss", 96'(rd_miss_cnt_o), 96'(m_rm));
    chk(wr_hit_cnt_o == CW'(m_wh), "R11 wr_hit", 96'(wr_hit_cnt_o), 96'(m_wh));
    chk(wr_miss_cnt_o == CW'(m_wm), "R11 wr_miss", 96'(wr_miss_cnt_o), 96'(m_wm));
    chk(hit_total_o == 17'(m_rh + m_wh), "R11 hit_total", 96'(hit_total_o), 96'(m_rh + m_wh));
    chk(miss_total_o == 17'(m_rm + m_wm), "R11 miss_total", 96'(miss_total_o), 96'(m_rm + m_wm));
    chk(acc_total_o == 17'(m_rh + m_rm + m_wh + m_wm), "R11 acc_total",
        96'(acc_total_o), 96'(m_rh + m_rm + m_wh + m_wm));
  endtask

  task automatic model_edge();
    int li = m_find(acc_va_i[31:12], acc_asid_i);
    if (acc_valid_i) begin
      if (acc_kind_i == 2'd1) begin if (li >= 0) m_wh++; else m_wm++; end
      else begin if (li >= 0) m_rh++; else m_rm++; end
    end
    m_warn = wr_en_i && (wr_idx_i >= N);
    if (flush_i) begin
      for (int i = 0; i < N; i++) m_tbl[i] = '0;
      m_rr = 0;
    end else begin
      if (wr_en_i && wr_idx_i < N) m_tbl[wr_idx_i] = wr_entry_i;
      if (rr_adv_i) m_rr = (m_rr + 1) % N;
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    compare_all();
    model_edge();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    acc_valid_i = 0; wr_en_i = 0; rr_adv_i = 0; flush_i = 0;
  endtask

  task automatic wr(int idx, logic [EW-1:0] e);
    idle(); wr_en_i = 1; wr_idx_i = (IW+1)'(idx); wr_entry_i = e; tick(); wr_en_i = 0;
  endtask

  task automatic acc(logic [1:0] k, logic [31:0] va, logic [7:0] asid);
    idle(); acc_valid_i = 1; acc_kind_i = k; acc_va_i = va; acc_asid_i = asid;
  endtask

  logic [19:0] pool [4] = '{20'h12345, 20'h12340, 20'h00001, 20'hABCDE};

  initial begin
    for (int i = 0; i < N; i++) m_tbl[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    #2;
    // R12 reset state
    chk(lk_hit_o == 0 && rr_idx_o == 0 && rd_entry_o == 0 && acc_total_o == 0 && !wr_warn_o,
        "R12 reset", 96'({lk_hit_o, rr_idx_o, acc_total_o}), 96'(0));
    chk(pr_idx_o == -1, "R12 probe empty", 96'(pr_idx_o), 96'(4'hF));
    tick();

    wr(0, mk(20'h12345, 20'h0, 8'd5, 0, 1, 0, 20'h11111, 20'h0));
    wr(1, mk(20'h12340, 20'hF, 8'd7, 1, 0, 1, 20'h22222, 20'h33333));
    wr(2, mk(20'h12345, 20'h0, 8'd5, 0, 1, 1, 20'h44444, 20'h55555));
    wr(3, mk(20'h55555, 20'h0, 8'd5, 1, 0, 0, 20'h66666, 20'h0));

    acc(2'd0, 32'h1234_5000, 8'd5); #2;
    chk(lk_hit_o && lk_idx_o == 0, "R3 lowest wins", 96'(lk_idx_o), 96'(0));
    tick();
    acc(2'd0, 32'h1234_5000, 8'd9); #2;
    chk(lk_hit_o && lk_idx_o == 1, "R2 global bypass", 96'(lk_idx_o), 96'(1));
    tick();
    acc(2'd1, 32'h1234_A000, 8'd9); #2;
    chk(lk_hit_o && lk_idx_o == 1, "R1 masked bits", 96'(lk_idx_o), 96'(1));
    tick();
    acc(2'd1, 32'h1235_A000, 8'd9); #2;
    chk(!lk_hit_o, "R1 unmasked mismatch", 96'(lk_hit_o), 96'(0));
    tick();
    acc(2'd0, 32'h5555_5000, 8'd5); #2;
    chk(!lk_hit_o && lk_entry_o == 0, "R3 empty slot", 96'(lk_hit_o), 96'(0));
    tick();
    idle(); pr_vpn_i = 20'h12345; pr_asid_i = 8'd3; #2;
    chk(pr_idx_o == 1, "R4 probe global", 96'(pr_idx_o), 96'(1));
    pr_vpn_i = 20'h99999; #1;
    chk(pr_idx_o == -1, "R4 probe miss", 96'(pr_idx_o), 96'(4'hF));
    tick();

    wr(8, mk(20'h1, 20'h0, 8'd0, 1, 1, 1, 20'h1, 20'h1));
    wr(15, mk(20'h1, 20'h0, 8'd0, 1, 1, 1, 20'h1, 20'h1));
    idle(); #2;
    chk(wr_warn_o == 1, "R6 warn pulse", 96'(wr_warn_o), 96'(1));
    tick();

    for (int i = 0; i < 10; i++) begin idle(); rr_adv_i = i[0]; rd_idx_i = IW'(i); tick(); end
    for (int i = 0; i < 4; i++) begin acc(2'd2, 32'hA000_0000 | 32'(i), 8'd5); tick(); end
    acc(2'd3, 32'hB234_5001, 8'd5); tick();
    acc(2'd0, 32'h8000_0000, 8'd5); tick();
    acc(2'd1, 32'h2000_0002, 8'd5); tick();

    // flush with a competing write and step
    idle(); flush_i = 1; wr_en_i = 1; wr_idx_i = 0; wr_entry_i = '1; rr_adv_i = 1; tick();
    idle();
    for (int i = 0; i < N; i++) begin
      rd_idx_i = IW'(i); #1;
      chk(rd_entry_o == 0, "R7 flushed slot", 96'(rd_entry_o), 96'(0));
    end
    chk(rr_idx_o == 0 && acc_total_o != 0, "R7 pointer cleared, counts kept",
        96'({rr_idx_o, acc_total_o}), 96'(0));
    tick();

    for (int c = 0; c < 600; c++) begin
      logic [19:0] v = pool[$urandom_range(3)];
      acc_valid_i = ($urandom_range(1) == 1);
      acc_kind_i  = 2'($urandom_range(3));
      acc_va_i    = {pool[$urandom_range(3)] ^ 20'($urandom_range(1) << $urandom_range(7)),
                     12'($urandom)};
      if ($urandom_range(3) == 0) acc_va_i[31:28] = 4'($urandom);
      acc_asid_i  = 8'($urandom_range(3));
      pr_vpn_i    = pool[$urandom_range(3)];
      pr_asid_i   = 8'($urandom_range(3));
      wr_en_i     = ($urandom_range(2) == 0);
      wr_idx_i    = (IW+1)'($urandom_range(11));
      wr_entry_i  = mk(v, ($urandom_range(1) == 1) ? 20'hF : 20'h0, 8'($urandom_range(3)),
                       $urandom_range(3) == 0, $urandom_range(1) == 1, $urandom_range(3) == 0,
                       20'($urandom), 20'($urandom));
      rd_idx_i    = IW'($urandom_range(N - 1));
      rr_adv_i    = ($urandom_range(1) == 1);
      flush_i     = ($urandom_range(59) == 0);
      tick();
    end
    idle(); tick();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule